// File: doc/BRIEF.md
# Interrupt Arbiter and Vector Locator

This block sits at the instruction boundary of a processor core. When the core raises a boundary strobe, the block looks at four pending event sources: debug trap, system-management interrupt, non-maskable interrupt and maskable interrupt. It picks exactly one of them by fixed priority. A maskable request is only considered while the interrupt-enable flag is set. Selecting it starts a request/acknowledge exchange with an external interrupt controller, which returns an 8-bit vector.

Once the vector is known, the block computes the byte address of that vector's entry in the descriptor table. The calculation uses a base/limit table register and the current mode: the entry size is 4 bytes in real mode and 8 bytes in protected mode. The block flags reserved vectors and entries that run past the table limit. It then waits for the core to report the type of the fetched gate. An interrupt gate clears the enable flag, a trap gate leaves it as it is, and a task gate raises a one-cycle task-switch request.

The control is a four-state machine:
- `ST_IDLE` waits for a boundary strobe with a pending source.
- `ST_ACK` holds the acknowledge request until the controller answers.
- `ST_RESOLVE` presents the event and its entry address for one cycle.
- `ST_GATE` waits for the gate type.

Transitions:
- IDLE→ACK is taken when a maskable request wins.
- IDLE→RESOLVE is taken when any other source wins.
- ACK→RESOLVE is taken on the acknowledge cycle.
- RESOLVE→GATE is taken when a valid address was produced.
- RESOLVE→IDLE is taken for a system-management event, a reserved vector or a limit fault.
- GATE→IDLE is taken on the gate-valid cycle.

Top module: `irq_vector_locator`

## Requirements
- R1: On a boundary strobe in ST_IDLE with at least one source eligible, exactly one event is delivered. The winner follows debug > system-management > non-maskable > maskable. `ev_kind` encodes the winner as 0 debug, 1 system-management, 2 non-maskable, 3 maskable.
- R2: A maskable request is ignored while `if_flag` is 0: no acknowledge request and no event follow. The other three sources are delivered regardless of the flag.
- R3: A maskable win raises `ack_req` on the cycle after the boundary. `ack_req` stays high until a cycle with `ack` high. The vector on `ack_vector` in that cycle is the one used, and the event is presented in the following cycle.
- R4: A maskable event whose vector is below 32 raises `vector_err` during the event cycle, with `addr_valid` and `limit_fault` low.
- R5: The entry address is base + vector*4 when `mode_prot` is 0 and base + vector*8 when it is 1. Both use the mode and table register in force during the event cycle.
- R6: If the entry's last byte offset (offset + entry size − 1) exceeds the table limit, `limit_fault` is high and `addr_valid` is low during the event cycle.
- R7: After reset the table base is 0, the limit is 0x3FF, `if_flag` is 0, and `ack_req`, `ev_valid` and `task_switch` are low.
- R8: In ST_GATE, a `gate_valid` cycle ends the event. Gate code 2'b00 (interrupt gate) clears `if_flag` at that edge. Code 2'b01 (trap gate) and 2'b11 leave the flag unchanged. Code 2'b10 (task gate) drives `task_switch` high for that cycle only and leaves the flag unchanged.
- R9: Boundary strobes and pending sources are ignored while an event is in progress (any state other than ST_IDLE).
- R10: Debug events carry vector 1 and non-maskable events carry vector 2. System-management events carry vector 0, have no table lookup (`addr_valid`, `limit_fault` and `vector_err` all low) and return to ST_IDLE.
- R11: `if_wr` loads `if_wr_val` into `if_flag` at the next edge, unless an interrupt-gate clear happens on that same edge; the clear wins.
- R12: `tbl_wr` loads `tbl_base_in` and `tbl_limit_in` into the table register at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction-boundary strobe |
| dbg_pend | input | 1 | Debug trap pending |
| smi_pend | input | 1 | System-management interrupt pending |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| intr_pend | input | 1 | Maskable interrupt pending |
| ack_req | output | 1 | Acknowledge request to the interrupt controller |
| ack | input | 1 | Acknowledge from the controller, vector valid |
| ack_vector | input | 8 | Vector returned by the controller |
| mode_prot | input | 1 | 1 = protected mode (8-byte entries), 0 = real mode (4-byte entries) |
| tbl_wr | input | 1 | Table register write strobe |
| tbl_base_in | input | 32 | New table base |
| tbl_limit_in | input | 16 | New table limit |
| if_wr | input | 1 | Interrupt-enable flag write strobe |
| if_wr_val | input | 1 | Value written to the flag |
| gate_valid | input | 1 | Gate type of the fetched entry is valid |
| gate_type | input | 2 | 00 interrupt, 01 trap, 10 task, 11 other |
| ev_valid | output | 1 | Event cycle (ST_RESOLVE) |
| ev_kind | output | 2 | Winning source |
| ev_vector | output | 8 | Vector of the event |
| entry_addr | output | 32 | Table entry address |
| addr_valid | output | 1 | Address usable in this event cycle |
| limit_fault | output | 1 | Entry exceeds table limit |
| vector_err | output | 1 | Maskable vector lies in the reserved range |
| if_flag | output | 1 | Interrupt-enable flag |
| task_switch | output | 1 | Task-gate request pulse |

## Verification
The bench targets four kinds of error.
- All four sources asserted at once, and non-maskable together with maskable. A wrong priority chain would report the wrong `ev_kind`, or deliver two events.
- Table edges at the reset limit, under the reset base and a fixed entry size per mode: protected vector 127 against 128, and real vector 255. An off-by-one limit compare, or a shift of the wrong size, shows up as a spurious or missing `limit_fault`.
- Boundaries while the acknowledge is stalled. A design that re-arbitrates mid-event would change the captured kind.
- An interrupt-gate clear on the same edge as a flag write, and a vector of 31 against 32. A wrong priority lets the flag survive the clear, and an off-by-one reserved range mislabels the vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK     = 2'd1,
        ST_RESOLVE = 2'd2,
        ST_GATE    = 2'd3
    } irq_state_t;

    typedef enum logic [1:0] {
        EV_DBG  = 2'd0,
        EV_SMI  = 2'd1,
        EV_NMI  = 2'd2,
        EV_MASK = 2'd3
    } irq_kind_t;

    localparam logic [1:0] GT_INT  = 2'b00;
    localparam logic [1:0] GT_TRAP = 2'b01;
    localparam logic [1:0] GT_TASK = 2'b10;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_pkg::*;
(
    input  logic      dbg_pend,
    input  logic      smi_pend,
    input  logic      nmi_pend,
    input  logic      intr_pend,
    input  logic      if_flag,
    output logic      any_win,
    output irq_kind_t win_kind
);
    logic intr_ok;

    assign intr_ok = intr_pend && if_flag;
    assign any_win = dbg_pend || smi_pend || nmi_pend || intr_ok;

    always_comb begin
        if (dbg_pend)      win_kind = EV_DBG;
        else if (smi_pend) win_kind = EV_SMI;
        else if (nmi_pend) win_kind = EV_NMI;
        else               win_kind = EV_MASK;
    end
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16,
    parameter int VEC_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [VEC_W-1:0]  vec,
    input  logic              prot,
    output logic [ADDR_W-1:0] addr,
    output logic              fault
);
    localparam int OFF_W = VEC_W + 3;
    localparam int CMP_W = ((OFF_W > LIM_W) ? OFF_W : LIM_W) + 1;

    logic [OFF_W-1:0] offset;
    logic [OFF_W-1:0] last_byte;

    always_comb begin
        if (prot) begin
            offset    = {vec, 3'b000};
            last_byte = offset + OFF_W'(7);
        end else begin
            offset    = {1'b0, vec, 2'b00};
            last_byte = offset + OFF_W'(3);
        end
        fault = CMP_W'(last_byte) > CMP_W'(limit);
        addr  = base + ADDR_W'(offset);
    end
endmodule

// File: rtl/irq_vector_locator.sv
module irq_vector_locator
    import irq_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          LIM_W   = 16,
    parameter int          VEC_W   = 8,
    parameter int          RSVD_N  = 32,
    parameter int          DBG_VEC = 1,
    parameter int          NMI_VEC = 2,
    parameter logic [15:0] LIM_RST = 16'h03FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              dbg_pend,
    input  logic              smi_pend,
    input  logic              nmi_pend,
    input  logic              intr_pend,
    output logic              ack_req,
    input  logic              ack,
    input  logic [VEC_W-1:0]  ack_vector,
    input  logic              mode_prot,
    input  logic              tbl_wr,
    input  logic [ADDR_W-1:0] tbl_base_in,
    input  logic [LIM_W-1:0]  tbl_limit_in,
    input  logic              if_wr,
    input  logic              if_wr_val,
    input  logic              gate_valid,
    input  logic [1:0]        gate_type,
    output logic              ev_valid,
    output logic [1:0]        ev_kind,
    output logic [VEC_W-1:0]  ev_vector,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              addr_valid,
    output logic              limit_fault,
    output logic              vector_err,
    output logic              if_flag,
    output logic              task_switch
);
    irq_state_t        st_q, st_d;
    irq_kind_t         kind_q;
    irq_kind_t         win_kind;
    logic              any_win;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] base_q;
    logic [LIM_W-1:0]  lim_q;
    logic              if_q;
    logic              calc_fault;
    logic [ADDR_W-1:0] calc_addr;
    logic              is_smi, is_rsvd, gate_clear, start_ev;

    irq_prio_sel u_prio (
        .dbg_pend (dbg_pend),
        .smi_pend (smi_pend),
        .nmi_pend (nmi_pend),
        .intr_pend(intr_pend),
        .if_flag  (if_q),
        .any_win  (any_win),
        .win_kind (win_kind)
    );

    irq_entry_calc #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .VEC_W(VEC_W)) u_calc (
        .base (base_q),
        .limit(lim_q),
        .vec  (vec_q),
        .prot (mode_prot),
        .addr (calc_addr),
        .fault(calc_fault)
    );

    assign start_ev   = (st_q == ST_IDLE) && boundary && any_win;
    assign gate_clear = (st_q == ST_GATE) && gate_valid && (gate_type == GT_INT);

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start_ev) st_d = (win_kind == EV_MASK) ? ST_ACK : ST_RESOLVE;
            ST_ACK:     if (ack) st_d = ST_RESOLVE;
            ST_RESOLVE: st_d = addr_valid ? ST_GATE : ST_IDLE;
            ST_GATE:    if (gate_valid) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Event capture, flag and table register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= EV_DBG;
            vec_q  <= '0;
            if_q   <= 1'b0;
            base_q <= '0;
            lim_q  <= LIM_W'(LIM_RST);
        end else begin
            if (start_ev) begin
                kind_q <= win_kind;
                unique case (win_kind)
                    EV_DBG:  vec_q <= VEC_W'(DBG_VEC);
                    EV_NMI:  vec_q <= VEC_W'(NMI_VEC);
                    default: vec_q <= '0;
                endcase
            end else if ((st_q == ST_ACK) && ack) begin
                vec_q <= ack_vector;
            end
            if (gate_clear)  if_q <= 1'b0;
            else if (if_wr)  if_q <= if_wr_val;
            if (tbl_wr) begin
                base_q <= tbl_base_in;
                lim_q  <= tbl_limit_in;
            end
        end
    end

    // Outputs
    always_comb begin
        is_smi      = (kind_q == EV_SMI);
        is_rsvd     = (kind_q == EV_MASK) && (int'(vec_q) < RSVD_N);
        ev_valid    = (st_q == ST_RESOLVE);
        ev_kind     = kind_q;
        ev_vector   = vec_q;
        entry_addr  = calc_addr;
        vector_err  = ev_valid && is_rsvd;
        limit_fault = ev_valid && !is_smi && !is_rsvd && calc_fault;
        addr_valid  = ev_valid && !is_smi && !is_rsvd && !calc_fault;
        ack_req     = (st_q == ST_ACK);
        if_flag     = if_q;
        task_switch = (st_q == ST_GATE) && gate_valid && (gate_type == GT_TASK);
    end

    a_r1_debug_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && boundary && dbg_pend) |=> (ev_valid && ev_kind == 2'd0));

    a_r2_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && boundary && !if_q && !dbg_pend && !smi_pend && !nmi_pend)
        |=> (!ack_req && !ev_valid));

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack) |=> ack_req);

    a_r3_ack_resolve: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack) |=> (ev_valid && ev_vector == $past(ack_vector)));

    a_r4_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        vector_err |-> (!addr_valid && !limit_fault));

    a_r6_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault |-> !addr_valid);

    a_r8_task_single: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> !task_switch);

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !addr_valid) |=> (!ev_valid && !ack_req));
endmodule

// File: tb/irq_vector_locator_tb.sv
module irq_vector_locator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 0, dbg_pend = 0, smi_pend = 0, nmi_pend = 0, intr_pend = 0;
    logic        ack = 0, mode_prot = 0, tbl_wr = 0, if_wr = 0, if_wr_val = 0, gate_valid = 0;
    logic [7:0]  ack_vector = 0;
    logic [31:0] tbl_base_in = 0;
    logic [15:0] tbl_limit_in = 0;
    logic [1:0]  gate_type = 0;
    logic        ack_req, ev_valid, addr_valid, limit_fault, vector_err, if_flag, task_switch;
    logic [1:0]  ev_kind;
    logic [7:0]  ev_vector;
    logic [31:0] entry_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state
    int ph = 0, mk = 0, mv = 0, mif = 0, mlim = 'h3FF;
    longint mbase = 0;

    always #10 clk = ~clk;

    irq_vector_locator u_dut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .dbg_pend(dbg_pend),
        .smi_pend(smi_pend), .nmi_pend(nmi_pend), .intr_pend(intr_pend),
        .ack_req(ack_req), .ack(ack), .ack_vector(ack_vector), .mode_prot(mode_prot),
        .tbl_wr(tbl_wr), .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in),
        .if_wr(if_wr), .if_wr_val(if_wr_val), .gate_valid(gate_valid), .gate_type(gate_type),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_vector(ev_vector), .entry_addr(entry_addr),
        .addr_valid(addr_valid), .limit_fault(limit_fault), .vector_err(vector_err),
        .if_flag(if_flag), .task_switch(task_switch)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Compare outputs against the model, advance the model, move to next negedge
    task automatic step();
        int e_ev, e_err, e_flt, e_av, sz, off, nph, win;
        #1;
        e_ev = (ph == 2); e_err = 0; e_flt = 0; e_av = 0;
        if (e_ev && mk != 1) begin
            if (mk == 3 && mv < 32) e_err = 1;
            else begin
                sz = mode_prot ? 8 : 4;
                off = mv * sz;
                if (off + sz - 1 > mlim) e_flt = 1; else e_av = 1;
            end
        end
        chk("R3 ack_req", ack_req, ph == 1);
        chk("R1 ev_valid", ev_valid, e_ev);
        if (e_ev) begin
            chk("R1 ev_kind", ev_kind, mk);
            chk("R10 ev_vector", ev_vector, mv);
        end
        chk("R4 vector_err", vector_err, e_err);
        chk("R6 limit_fault", limit_fault, e_flt);
        chk("R6 addr_valid", addr_valid, e_av);
        if (e_av) chk("R5 entry_addr", entry_addr, (mbase + mv * (mode_prot ? 8 : 4)) & 64'hFFFF_FFFF);
        chk("R11 if_flag", if_flag, mif);
        chk("R8 task_switch", task_switch, ph == 3 && gate_valid && gate_type == 2'b10);
        // advance
        nph = ph;
        case (ph)
            0: if (boundary) begin
                   win = dbg_pend ? 0 : smi_pend ? 1 : nmi_pend ? 2 : (intr_pend && mif) ? 3 : -1;
                   if (win >= 0) begin
                       mk = win;
                       mv = (win == 0) ? 1 : (win == 2) ? 2 : 0;
                       nph = (win == 3) ? 1 : 2;
                   end
               end
            1: if (ack) begin mv = ack_vector; nph = 2; end
            2: nph = e_av ? 3 : 0;
            default: if (gate_valid) nph = 0;
        endcase
        if (ph == 3 && gate_valid && gate_type == 2'b00) mif = 0;
        else if (if_wr) mif = if_wr_val;
        if (tbl_wr) begin mbase = tbl_base_in; mlim = tbl_limit_in; end
        ph = nph;
        @(negedge clk);
    endtask

    task automatic fire(bit d, bit s, bit n, bit i);
        {dbg_pend, smi_pend, nmi_pend, intr_pend} = {d, s, n, i};
        boundary = 1;
        step();
        boundary = 0;
        {dbg_pend, smi_pend, nmi_pend, intr_pend} = 4'b0;
    endtask

    task automatic give_ack(logic [7:0] v);
        ack = 1; ack_vector = v; step(); ack = 0;
    endtask

    task automatic gate(logic [1:0] t);
        gate_valid = 1; gate_type = t; step(); gate_valid = 0;
    endtask

    task automatic set_if(bit v);
        if_wr = 1; if_wr_val = v; step(); if_wr = 0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7: reset state
        #1;
        chk("R7 if_flag reset", if_flag, 0);
        chk("R7 ack_req reset", ack_req, 0);
        chk("R7 ev_valid reset", ev_valid, 0);
        chk("R7 task_switch reset", task_switch, 0);
        step();
        // R10 debug alone, real mode: vector 1 at address 4
        fire(1, 0, 0, 0);
        chk("R10 debug vector", ev_vector, 1);
        chk("R5 debug real addr", entry_addr, 4);
        step(); gate(2'b01);
        // R1 all four pending, IF set: debug wins, interrupt gate clears IF (R8)
        set_if(1);
        fire(1, 1, 1, 1);
        chk("R1 all pending winner", ev_kind, 0);
        step(); gate(2'b00);
        chk("R8 interrupt gate clears flag", if_flag, 0);
        // R10 SMI over NMI and INTR, no lookup
        fire(0, 1, 1, 1);
        chk("R10 smi no address", addr_valid, 0);
        step();
        chk("R10 smi back to idle", ev_valid, 0);
        // R1 NMI over INTR; R2 NMI delivered with IF=0
        fire(0, 0, 1, 1);
        chk("R2 nmi ignores flag", ev_kind, 2);
        step(); gate(2'b01);
        chk("R8 trap keeps flag", if_flag, 0);
        // R2 maskable masked
        fire(0, 0, 0, 1);
        chk("R2 masked no ack", ack_req, 0);
        step();
        chk("R2 masked no event", ev_valid, 0);
        // R3/R9 stall with boundaries during ACK
        set_if(1);
        fire(0, 0, 0, 1);
        chk("R3 ack_req raised", ack_req, 1);
        step();
        fire(1, 1, 1, 0);
        chk("R9 boundary ignored in ack", ack_req, 1);
        give_ack(8'h40);
        chk("R9 kind stays maskable", ev_kind, 3);
        chk("R5 real addr vec 0x40", entry_addr, 32'h100);
        step();
        fire(1, 0, 0, 0);
        chk("R9 boundary ignored in gate wait", ev_valid, 0);
        gate_valid = 1; gate_type = 2'b10; #1;
        chk("R8 task pulse", task_switch, 1);
        step(); gate_valid = 0;
        chk("R8 task keeps flag", if_flag, 1);
        // R4 reserved vector boundary 31 vs 32
        fire(0, 0, 0, 1); give_ack(8'd31);
        chk("R4 vector 31 error", vector_err, 1);
        step();
        fire(0, 0, 0, 1); give_ack(8'd32);
        chk("R4 vector 32 ok", vector_err, 0);
        step(); gate(2'b01);
        // R6/R7 protected, reset limit 0x3FF
        mode_prot = 1;
        fire(0, 0, 0, 1); give_ack(8'd127);
        chk("R6 prot vec 127 fits", addr_valid, 1);
        chk("R5 prot addr 127", entry_addr, 32'h3F8);
        step(); gate(2'b01);
        fire(0, 0, 0, 1); give_ack(8'd128);
        chk("R6 prot vec 128 faults", limit_fault, 1);
        step();
        mode_prot = 0;
        fire(0, 0, 0, 1); give_ack(8'd255);
        chk("R6 real vec 255 fits", addr_valid, 1);
        chk("R5 real addr 255", entry_addr, 32'h3FC);
        step();
        // R11 clear wins over same-edge write
        if_wr = 1; if_wr_val = 1; gate_valid = 1; gate_type = 2'b00;
        step();
        if_wr = 0; gate_valid = 0;
        chk("R11 clear beats write", if_flag, 0);
        set_if(1);
        // R12 table write
        tbl_wr = 1; tbl_base_in = 32'h0001_0000; tbl_limit_in = 16'h07FF; step(); tbl_wr = 0;
        mode_prot = 1;
        fire(0, 0, 0, 1); give_ack(8'd200);
        chk("R12 new base addr", entry_addr, 32'h0001_0640);
        chk("R12 new limit fits", addr_valid, 1);
        step(); gate(2'b01);
        fire(0, 0, 1, 0);
        chk("R5 nmi prot addr", entry_addr, 32'h0001_0010);
        step(); gate(2'b11);
        // Random phase, model compared every cycle
        for (int k = 0; k < 3000; k++) begin
            boundary   = ($urandom % 3) == 0;
            dbg_pend   = ($urandom % 9) == 0;
            smi_pend   = ($urandom % 9) == 0;
            nmi_pend   = ($urandom % 6) == 0;
            intr_pend  = ($urandom % 2) == 0;
            ack        = ($urandom % 3) == 0;
            ack_vector = 8'($urandom);
            gate_valid = ($urandom % 3) == 0;
            gate_type  = 2'($urandom);
            if_wr      = ($urandom % 7) == 0;
            if_wr_val  = ($urandom % 4) != 0;
            mode_prot  = 1'($urandom);
            tbl_wr     = ($urandom % 40) == 0;
            tbl_base_in  = $urandom;
            tbl_limit_in = 16'($urandom % 2300);
            step();
        end
        finish_run();
    end
endmodule